// File: doc/BRIEF.md
# Two-Bank Control Register File with Sync-Gated Start

This block sits behind a register write port. It holds the control settings of a timing generator in two banks. A bank-select register chooses which bank receives writes, and it can be reached from either bank. The first bank holds the main control settings. Writes to it land in a shadow copy. The shadow copy moves into the active copy, which drives the outputs, only on a vertical or horizontal drive edge. Those edges count only after a sync event has occurred. The second bank is a plain register file that takes effect as soon as it is written.

A sync event has two sources. One is a rising edge on the external SYNC pin, taken through a two-flop synchronizer. The other is a self-clearing software trigger register. A sync event drives a one-cycle counter reset toward the counter logic and arms the commit mechanism. Software first brings the timing core out of reset, loads the banks, selects master mode and sets the output enable. It then issues the sync. The staged settings appear at the first drive edge that follows.

Top module: `regbank_sync_ctl`

## Requirements
- R1: After rst_ni the block is in this state: bank 0 selected, core_rst_o high, master_o and out_en_o low, pwr_mode_o equal to the standby code 3, cnt_rst_o low. Every other register reads 0.
- R2: A write to address 0x7F sets the bank select to data bit 0, from either bank, in the cycle after the write. bank_o shows it, and 0 selects bank 1.
- R3: With bank 2 selected, a write to an address below 16 stores the 12-bit data at once. The data reads back on rd_data_o while bank 2 is selected, and the write leaves every bank-1 output unchanged.
- R4: With bank 1 selected, a write to a storable address (below 64, other than 0x10, 0x13 and 0x15) changes no output and no bank-1 read-back until a commit.
- R5: A commit copies all staged bank-1 values to the active copy. It happens on a clock where vd_edge_i or hd_edge_i is high, provided a sync event occurred on an earlier clock since the last reset. Drive edges before any sync event commit nothing.
- R6: A low-to-high change on sync_i drives cnt_rst_o high for exactly one cycle. That cycle begins at the second rising clock edge that samples sync_i high.
- R7: Writing bank-1 address 0x13 with data bit 0 set drives cnt_rst_o high for exactly the one cycle after the write.
- R8: A write to bank-1 address 0x15 sets the core run state from data bit 0 at once. core_rst_o is its inverse.
- R9: Writing bank-1 address 0x10 with data bit 0 set restores the full R1 state, including bank select, core hold and commit arming. With data bit 0 clear, the write has no effect.
- R10: master_o and out_en_o follow bit 0 of active bank-1 registers 0x20 and 0x11. pwr_mode_o follows active register 0x00.
- R11: Reads outside the selected bank's depth return 0, and writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 12 | Write data |
| rd_addr_i | input | 8 | Read-back address in the selected bank |
| sync_i | input | 1 | External sync pin, asynchronous |
| vd_edge_i | input | 1 | Vertical drive edge pulse |
| hd_edge_i | input | 1 | Horizontal drive edge pulse |
| cnt_rst_o | output | 1 | One-cycle counter reset on a sync event |
| core_rst_o | output | 1 | Timing core held in reset when high |
| master_o | output | 1 | Master timing mode |
| out_en_o | output | 1 | Outputs enable |
| pwr_mode_o | output | 12 | Active power-mode setting |
| bank_o | output | 1 | Selected bank (0 is bank 1, 1 is bank 2) |
| rd_data_o | output | 12 | Read-back data (bank-1 active copy or bank 2) |

## Verification
The bench first stages bank-1 writes and pulses drive edges before any sync. This separates a design that commits on every edge from one that waits for arming. Sync is then raised on the pin and, separately, through the software trigger, and the exact cycle of the counter reset is checked for each source. Bank-2 writes and writes outside either bank's depth are placed between staged bank-1 writes. This shows that routing follows the bank select. Soft reset is tried with data bit 0 clear and with it set. After the full reset, a drive edge shows that the commit arming was cleared too.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int AW = 8;
  localparam int DW = 12;
  localparam logic [AW-1:0] A_PWR   = 8'h00;
  localparam logic [AW-1:0] A_SRST  = 8'h10;
  localparam logic [AW-1:0] A_OEN   = 8'h11;
  localparam logic [AW-1:0] A_SSYNC = 8'h13;
  localparam logic [AW-1:0] A_CORE  = 8'h15;
  localparam logic [AW-1:0] A_MSTR  = 8'h20;
  localparam logic [AW-1:0] A_BANK  = 8'h7F;
  localparam logic [DW-1:0] PWR_STBY = 12'd3;
endpackage

// File: rtl/pin_rise_det.sv
module pin_rise_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_rise_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int DEPTH = 64,
  parameter int DW = 12,
  parameter logic [DW-1:0] RST0 = '0,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       we_i,
  input  logic [IW-1:0]              idx_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       commit_i,
  output logic [DEPTH-1:0][DW-1:0]   act_o
);
  localparam logic [DEPTH-1:0][DW-1:0] RST_IMG = {{((DEPTH-1)*DW){1'b0}}, RST0};

  logic [DEPTH-1:0][DW-1:0] sh_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= RST_IMG;
      act_q <= RST_IMG;
    end else if (clear_i) begin
      sh_q  <= RST_IMG;
      act_q <= RST_IMG;
    end else begin
      if (commit_i) act_q <= sh_q;
      if (we_i)     sh_q[idx_i] <= data_i;
    end
  end

  assign act_o = act_q;

  p_active_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clear_i) |=> $stable(act_q));
  p_shadow_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clear_i) |=> sh_q[$past(idx_i)] == $past(data_i));
endmodule

// File: rtl/flat_bank.sv
module flat_bank #(
  parameter int DEPTH = 16,
  parameter int DW = 12,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mem_q <= '0;
    else if (clear_i) mem_q <= '0;
    else if (we_i)    mem_q[idx_i] <= data_i;
  end

  assign rd_o = mem_q[rd_idx_i];

  p_b2_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clear_i) |=> $stable(mem_q));
endmodule

// File: rtl/regbank_sync_ctl.sv
module regbank_sync_ctl
  import regbank_pkg::*;
#(
  parameter int B1_DEPTH = 64,
  parameter int B2_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IW1 = $clog2(B1_DEPTH),
  localparam int IW2 = $clog2(B2_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          sync_i,
  input  logic          vd_edge_i,
  input  logic          hd_edge_i,
  output logic          cnt_rst_o,
  output logic          core_rst_o,
  output logic          master_o,
  output logic          out_en_o,
  output logic [DW-1:0] pwr_mode_o,
  output logic          bank_o,
  output logic [DW-1:0] rd_data_o
);
  logic bank_q, core_run_q, armed_q, sw_q;
  logic wr_b1, wr_b2, bank_wr, soft_rst, sw_set, core_wr;
  logic b1_store, b2_store, pin_rise, sync_evt, commit;
  logic [B1_DEPTH-1:0][DW-1:0] act_w;
  logic [DW-1:0] b2_rd;

  assign bank_wr  = wr_en_i && (wr_addr_i == A_BANK);
  assign wr_b1    = wr_en_i && !bank_q && !bank_wr;
  assign wr_b2    = wr_en_i &&  bank_q && !bank_wr;
  assign soft_rst = wr_b1 && (wr_addr_i == A_SRST) && wr_data_i[0];
  assign sw_set   = wr_b1 && (wr_addr_i == A_SSYNC) && wr_data_i[0];
  assign core_wr  = wr_b1 && (wr_addr_i == A_CORE);
  // immediate-action addresses never reach the shadow copy
  assign b1_store = wr_b1 && (wr_addr_i < AW'(B1_DEPTH)) &&
                    (wr_addr_i != A_SRST) && (wr_addr_i != A_SSYNC) &&
                    (wr_addr_i != A_CORE);
  assign b2_store = wr_b2 && (wr_addr_i < AW'(B2_DEPTH));

  pin_rise_det #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (sync_i),
    .rise_o (pin_rise)
  );

  assign sync_evt = pin_rise | sw_q;
  assign commit   = armed_q & (vd_edge_i | hd_edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= 1'b0;
      core_run_q <= 1'b0;
      armed_q    <= 1'b0;
      sw_q       <= 1'b0;
    end else if (soft_rst) begin
      bank_q     <= 1'b0;
      core_run_q <= 1'b0;
      armed_q    <= 1'b0;
      sw_q       <= 1'b0;
    end else begin
      if (bank_wr)  bank_q     <= wr_data_i[0];
      if (core_wr)  core_run_q <= wr_data_i[0];
      if (sync_evt) armed_q    <= 1'b1;
      sw_q <= sw_set;
    end
  end

  shadow_bank #(.DEPTH(B1_DEPTH), .DW(DW), .RST0(PWR_STBY)) i_b1 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (soft_rst),
    .we_i     (b1_store),
    .idx_i    (wr_addr_i[IW1-1:0]),
    .data_i   (wr_data_i),
    .commit_i (commit),
    .act_o    (act_w)
  );

  flat_bank #(.DEPTH(B2_DEPTH), .DW(DW)) i_b2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (soft_rst),
    .we_i     (b2_store),
    .idx_i    (wr_addr_i[IW2-1:0]),
    .data_i   (wr_data_i),
    .rd_idx_i (rd_addr_i[IW2-1:0]),
    .rd_o     (b2_rd)
  );

  assign cnt_rst_o  = sync_evt;
  assign core_rst_o = !core_run_q;
  assign master_o   = act_w[A_MSTR][0];
  assign out_en_o   = act_w[A_OEN][0];
  assign pwr_mode_o = act_w[A_PWR];
  assign bank_o     = bank_q;

  always_comb begin
    rd_data_o = '0;
    if (bank_q) begin
      if (rd_addr_i < AW'(B2_DEPTH)) rd_data_o = b2_rd;
    end else if (rd_addr_i < AW'(B1_DEPTH)) begin
      rd_data_o = act_w[rd_addr_i[IW1-1:0]];
    end
  end

  p_bank_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bank_wr && !soft_rst) |=> $stable(bank_o));
  p_core_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && !core_wr) |=> core_rst_o);
  p_soft_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!bank_o && core_rst_o && !master_o && !out_en_o && pwr_mode_o == PWR_STBY));
  p_unarmed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !soft_rst) |=> ($stable(master_o) && $stable(out_en_o) && $stable(pwr_mode_o)));
endmodule

// File: tb/test_regbank_sync_ctl.sv
module test_regbank_sync_ctl;
  logic clk = 0, rst_n = 0;
  logic we = 0, sync = 0, vd = 0, hd = 0;
  logic [7:0] wa = 0, ra = 0;
  logic [11:0] wd = 0;
  logic cnt_rst, core_rst, master, out_en, bank;
  logic [11:0] pwr, rd;
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int sh[64], ac[64], b2[16];
  int m_bank, m_run, m_armed, m_sw, p1, p2, p3;

  always #5 clk = ~clk;

  regbank_sync_ctl i_regbank_sync_ctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .sync_i(sync), .vd_edge_i(vd), .hd_edge_i(hd),
    .cnt_rst_o(cnt_rst), .core_rst_o(core_rst), .master_o(master),
    .out_en_o(out_en), .pwr_mode_o(pwr), .bank_o(bank), .rd_data_o(rd)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_defaults();
    for (int i = 0; i < 64; i++) begin sh[i] = 0; ac[i] = 0; end
    for (int i = 0; i < 16; i++) b2[i] = 0;
    sh[0] = 3; ac[0] = 3;
    m_bank = 0; m_run = 0; m_armed = 0; m_sw = 0;
  endtask

  function automatic int m_rd(int a);
    if (m_bank == 1) return (a < 16) ? b2[a] : 0;
    return (a < 64) ? ac[a] : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_defaults(); p1 = 0; p2 = 0; p3 = 0;
    end else begin
      int a, d, nsw;
      bit ev;
      a = int'(wa); d = int'(wd);
      ev = (p2 == 1 && p3 == 0) || m_sw == 1;
      if (we && m_bank == 0 && a == 16 && (d & 1) == 1) begin
        m_defaults();
      end else begin
        if (m_armed == 1 && (vd || hd))
          for (int i = 0; i < 64; i++) ac[i] = sh[i];
        if (ev) m_armed = 1;
        nsw = (we && m_bank == 0 && a == 19 && (d & 1) == 1) ? 1 : 0;
        if (we) begin
          if (a == 127) m_bank = d & 1;
          else if (m_bank == 1) begin
            if (a < 16) b2[a] = d;
          end else if (a == 21) m_run = d & 1;
          else if (a != 16 && a != 19 && a < 64) sh[a] = d;
        end
        m_sw = nsw;
      end
      p3 = p2; p2 = p1; p1 = int'(sync);
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    if (rst_n && !done) begin
      #2;
      chk("R2 bank_o", int'(bank), m_bank);
      chk("R8 core_rst_o", int'(core_rst), 1 - m_run);
      chk("R10 master_o", int'(master), ac[32] & 1);
      chk("R10 out_en_o", int'(out_en), ac[17] & 1);
      chk("R4 pwr_mode_o", int'(pwr), ac[0]);
      chk("R6/R7 cnt_rst_o", int'(cnt_rst), ((p2 == 1 && p3 == 0) || m_sw == 1) ? 1 : 0);
      chk("R3/R4/R11 rd_data_o", int'(rd), m_rd(int'(ra)));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; wa = 8'(a); wd = 12'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic pulse_vd();
    @(negedge clk); vd = 1; @(negedge clk); vd = 0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    ra = 8'(a); #1; chk(req, int'(rd), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bank", int'(bank), 0);
    chk("R1 core_rst", int'(core_rst), 1);
    chk("R1 master", int'(master), 0);
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 pwr standby", int'(pwr), 3);
    chk("R1 cnt_rst", int'(cnt_rst), 0);
    rd_chk("R1 reg zero", 5, 0);

    wr(8'h15, 1);
    chk("R8 core released", int'(core_rst), 0);
    wr(8'h20, 1); wr(8'h11, 1); wr(8'h00, 4); wr(8'h05, 12'hABC);
    chk("R4 master staged", int'(master), 0);
    rd_chk("R4 reg staged", 5, 0);
    pulse_vd();
    chk("R5 no commit before sync", int'(master), 0);
    chk("R5 pwr unchanged", int'(pwr), 3);

    wr(8'h7F, 1);
    chk("R2 bank 2 selected", int'(bank), 1);
    wr(3, 12'h123); wr(8'h20, 12'h777);
    rd_chk("R3 bank2 readback", 3, 12'h123);
    rd_chk("R11 bank2 out of range", 8'h20, 0);
    chk("R3 bank1 untouched", int'(master), 0);
    wr(8'h7F, 0);
    chk("R2 back to bank 1", int'(bank), 0);

    @(negedge clk); sync = 1;
    @(negedge clk); chk("R6 not yet", int'(cnt_rst), 0);
    @(negedge clk); chk("R6 pulse", int'(cnt_rst), 1);
    @(negedge clk); chk("R6 one cycle", int'(cnt_rst), 0);
    @(negedge clk); hd = 1; @(negedge clk); hd = 0;
    chk("R10 master committed", int'(master), 1);
    chk("R10 out_en committed", int'(out_en), 1);
    chk("R10 pwr committed", int'(pwr), 4);
    rd_chk("R5 reg committed", 5, 12'hABC);

    wr(8'h20, 0);
    chk("R4 master held", int'(master), 1);
    pulse_vd();
    chk("R5 master recommitted", int'(master), 0);

    wr(8'h13, 1);
    chk("R7 soft sync pulse", int'(cnt_rst), 1);
    @(negedge clk); chk("R7 self clear", int'(cnt_rst), 0);

    wr(8'h50, 12'h555);
    rd_chk("R11 bank1 out of range", 8'h50, 0);

    wr(8'h10, 0);
    chk("R9 data0 no effect", int'(core_rst), 0);
    chk("R9 data0 keeps pwr", int'(pwr), 4);
    wr(8'h10, 1);
    chk("R9 core held", int'(core_rst), 1);
    chk("R9 pwr standby", int'(pwr), 3);
    chk("R9 out_en off", int'(out_en), 0);
    rd_chk("R9 reg cleared", 5, 0);
    wr(8'h20, 1);
    pulse_vd();
    chk("R9 arming cleared", int'(master), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule